// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs the external bus of an 8-bit microcontroller core. The address and data share one set of lines. The core hands over one request at a time: an instruction fetch, a data read or a data write, together with a 16-bit address and, for a write, a data byte. The sequencer then plays out the matching bus cycle in whole clock steps. It raises the address latch strobe, drives the low address byte so that an external latch can capture it, and turns the shared lines around. It then pulses the fetch strobe or the read or write strobe.

Fetched or read bytes are captured from the shared lines on the last clock that their strobe is low. The captured byte is returned on a result port together with a one-clock done pulse. The shared lines are modelled as three signals: an outgoing value, an incoming value and an output enable. The high address byte has a port of its own.

Fetch cycles are short and last 7 clocks. Data cycles use a longer strobe and last 12 clocks. A new request can be accepted during the final clock of a cycle, so cycles can follow each other with no gap.

Top module: `xbus_seq`

## Requirements
- R1: After a request is accepted, `ale` is high for exactly the first 2 clocks of the cycle (phases 0 and 1). It is low for the rest of the cycle.
- R2: The low address byte is driven on `ad_out`, with `ad_oe` high, during phases 1 and 2. This is one clock before `ale` falls and one clock after. `ad_oe` is low in phase 0.
- R3: In a fetch cycle (`req_kind` = 2'b00), `psen_n` is low during phases 3, 4 and 5. `rd_n` and `wr_n` stay high.
- R4: In a read cycle (`req_kind` = 2'b01), `rd_n` is low during phases 5 through 10. In a write cycle (`req_kind[1]` = 1, so 2'b10 and 2'b11 are both writes), `wr_n` is low during the same phases.
- R5: In fetch and read cycles, `ad_oe` is low from phase 3 to the end of the cycle. `ad_oe` is also low in phase 0 of the next cycle, which gives the external device two undriven clocks after `rd_n` rises.
- R6: In a write cycle, the write byte is driven on `ad_out` with `ad_oe` high during phases 4 through 11. This is one clock before `wr_n` falls and one clock after it rises.
- R7: A fetch cycle lasts 7 clocks and a data cycle lasts 12 clocks. `req_ready` is high when idle and in the last phase of a cycle. A request accepted in that last phase starts its phase 0 on the very next clock.
- R8: `done` is high for exactly one clock, in the last phase of every cycle. For a fetch or read, `rdata` then holds the `ad_in` value sampled on the last clock that the strobe was low. A write leaves `rdata` unchanged.
- R9: `a_hi` carries the high address byte of the current request for the whole cycle, from phase 0 to the last phase.
- R10: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R11: While `req_ready` is low, `req_valid` and the request fields have no effect. The running cycle continues unchanged.
- R12: With `rst` high, the block is idle: `ale` low, all strobes high, `ad_oe` low, `done` low, `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one step per oscillator period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request is taken at this clock edge if valid |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured fetch or read byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Fetch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_in | input | 8 | Value seen on the shared lines |
| ad_oe | output | 1 | Shared line output enable |
| a_hi | output | 8 | High address byte |

## Verification
The bench aims at turnaround edges and cycle boundaries. If the address window starts one clock late, the external latch misses the byte when `ale` falls. If the bus is released late, it clashes with the fetch or read strobe. If a read is followed at once by another cycle with a phase-0 address drive, it tramples the device's float time. The external model presents read data only from the second strobe-low clock and returns a different value once the strobe is high, so a design that samples one clock late or too early returns the wrong byte. Write cycles using kind 2'b11, back-to-back requests in the last phase, and stray requests pulsed while busy expose a sequencer that miscounts its length, inserts an idle gap, or restarts mid-cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Control outputs for one phase of a bus cycle
  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic drv_addr;
    logic drv_data;
    logic last_low;
  } bus_ctl_t;

  function automatic cyc_e kind_of(input logic [1:0] k);
    if (k[1])      return CYC_WRITE;
    else if (k[0]) return CYC_READ;
    else           return CYC_FETCH;
  endfunction

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
  import xbus_pkg::*;
#(
  parameter int FETCH_LEN = 7,
  parameter int DATA_LEN  = 12,
  parameter int PHW       = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_req,
  input  cyc_e           start_kind,
  output logic           ready,
  output logic           start,
  output cyc_e           kind_q,
  output logic           busy_n,
  output cyc_e           kind_n,
  output logic [PHW-1:0] ph_n
);

  localparam logic [PHW-1:0] F_LAST = PHW'(FETCH_LEN - 1);
  localparam logic [PHW-1:0] D_LAST = PHW'(DATA_LEN - 1);

  logic           busy_q;
  logic [PHW-1:0] ph_q;
  logic           last;

  always_comb begin
    last  = busy_q && (ph_q == ((kind_q == CYC_FETCH) ? F_LAST : D_LAST));
    ready = !busy_q || last;
    start = start_req && ready;
    busy_n = busy_q;
    kind_n = kind_q;
    ph_n   = ph_q;
    if (start) begin
      busy_n = 1'b1;
      kind_n = start_kind;
      ph_n   = '0;
    end else if (last) begin
      busy_n = 1'b0;
      ph_n   = '0;
    end else if (busy_q) begin
      ph_n = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= CYC_FETCH;
      ph_q   <= '0;
    end else begin
      busy_q <= busy_n;
      kind_q <= kind_n;
      ph_q   <= ph_n;
    end
  end

  // R7
  ph_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ph_q <= D_LAST));

  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ready) |=> (busy_q && ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ALE_CLKS  = 2,
  parameter int FETCH_GAP = 1,
  parameter int FETCH_LOW = 3,
  parameter int DATA_GAP  = 3,
  parameter int DATA_LOW  = 6,
  parameter int PHW       = 4
) (
  input  logic           active,
  input  cyc_e           kind,
  input  logic [PHW-1:0] ph,
  output bus_ctl_t       ctl
);

  localparam logic [PHW-1:0] ALE_END = PHW'(ALE_CLKS);
  localparam logic [PHW-1:0] ADR_BEG = PHW'(ALE_CLKS - 1);
  localparam logic [PHW-1:0] F_BEG   = PHW'(ALE_CLKS + FETCH_GAP);
  localparam logic [PHW-1:0] F_END   = PHW'(ALE_CLKS + FETCH_GAP + FETCH_LOW - 1);
  localparam logic [PHW-1:0] D_BEG   = PHW'(ALE_CLKS + DATA_GAP);
  localparam logic [PHW-1:0] D_END   = PHW'(ALE_CLKS + DATA_GAP + DATA_LOW - 1);
  localparam logic [PHW-1:0] W_BEG   = PHW'(ALE_CLKS + DATA_GAP - 1);
  localparam logic [PHW-1:0] W_END   = PHW'(ALE_CLKS + DATA_GAP + DATA_LOW);

  logic in_f, in_d;

  always_comb begin
    in_f = (ph >= F_BEG) && (ph <= F_END);
    in_d = (ph >= D_BEG) && (ph <= D_END);
    ctl  = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
             drv_addr: 1'b0, drv_data: 1'b0, last_low: 1'b0};
    if (active) begin
      ctl.ale      = ph < ALE_END;
      ctl.drv_addr = (ph == ADR_BEG) || (ph == ALE_END);
      unique case (kind)
        CYC_FETCH: begin
          ctl.psen_n   = !in_f;
          ctl.last_low = ph == F_END;
        end
        CYC_READ: begin
          ctl.rd_n     = !in_d;
          ctl.last_low = ph == D_END;
        end
        default: begin
          ctl.wr_n     = !in_d;
          ctl.drv_data = (ph >= W_BEG) && (ph <= W_END);
          ctl.last_low = ph == D_END;
        end
      endcase
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ALE_CLKS  = 2,
  parameter int FETCH_GAP = 1,
  parameter int FETCH_LOW = 3,
  parameter int DATA_GAP  = 3,
  parameter int DATA_LOW  = 6,
  parameter int AW        = 16,
  parameter int DW        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  input  logic [DW-1:0]    ad_in,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi
);

  localparam int FETCH_LEN = ALE_CLKS + FETCH_GAP + FETCH_LOW + 1;
  localparam int DATA_LEN  = ALE_CLKS + DATA_GAP + DATA_LOW + 1;
  localparam int PHW       = $clog2(DATA_LEN + 1);

  logic           start, busy_n;
  cyc_e           kind_q, kind_n;
  logic [PHW-1:0] ph_n;
  bus_ctl_t       ctl_n;
  logic [AW-1:0]  addr_q, addr_n;
  logic [DW-1:0]  wdata_q, wdata_n;
  logic           smp_q;

  xbus_timer #(.FETCH_LEN(FETCH_LEN), .DATA_LEN(DATA_LEN), .PHW(PHW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start_req  (req_valid),
    .start_kind (kind_of(req_kind)),
    .ready      (req_ready),
    .start      (start),
    .kind_q     (kind_q),
    .busy_n     (busy_n),
    .kind_n     (kind_n),
    .ph_n       (ph_n)
  );

  xbus_decode #(
    .ALE_CLKS(ALE_CLKS), .FETCH_GAP(FETCH_GAP), .FETCH_LOW(FETCH_LOW),
    .DATA_GAP(DATA_GAP), .DATA_LOW(DATA_LOW), .PHW(PHW)
  ) u_decode (
    .active (busy_n),
    .kind   (kind_n),
    .ph     (ph_n),
    .ctl    (ctl_n)
  );

  always_comb begin
    addr_n  = start ? req_addr  : addr_q;
    wdata_n = start ? req_wdata : wdata_q;
  end

  // Outputs are registered from the next-phase decode
  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      psen_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      a_hi    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      smp_q   <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      ale     <= ctl_n.ale;
      psen_n  <= ctl_n.psen_n;
      rd_n    <= ctl_n.rd_n;
      wr_n    <= ctl_n.wr_n;
      ad_oe   <= ctl_n.drv_addr | ctl_n.drv_data;
      ad_out  <= ctl_n.drv_addr ? addr_n[DW-1:0] : (ctl_n.drv_data ? wdata_n : '0);
      a_hi    <= addr_n[AW-1:DW];
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      smp_q   <= ctl_n.last_low;
      done    <= smp_q;
      if (smp_q && kind_q != CYC_WRITE) rdata <= ad_in;
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~psen_n, ~rd_n, ~wr_n}));

  // R1
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (ale ##1 !ale));

  // R5
  float_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(a_hi));

endmodule

// File: tb/xbus_seq_test.sv
module xbus_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, done, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] rdata, ad_out, a_hi;
  logic [7:0] ad_in = 8'hEE;

  always #10 clk = ~clk;

  xbus_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi)
  );

  typedef struct { int kind; logic [7:0] val; } exp_t;
  exp_t sbq[$];

  int vectors = 0;
  int miscompares = 0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int kmap(input logic [1:0] k);
    return k[1] ? 2 : (k[0] ? 1 : 0);
  endfunction

  function automatic int blen(input int k);
    return (k == 0) ? 7 : 12;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // External device model: latch low address, return data from 2nd low clock
  logic [7:0] lat_lo = '0;
  int lowcnt = 0;
  always @(negedge clk) begin
    if (ale && ad_oe) lat_lo = ad_out;
    if (!psen_n || !rd_n) lowcnt = lowcnt + 1; else lowcnt = 0;
    ad_in = (lowcnt >= 2) ? memf({a_hi, lat_lo}) : 8'hEE;
  end

  // Driver: pushes expected items as each request is taken
  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    exp_t e;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    e.kind = kmap(k);
    e.val  = (e.kind == 2) ? d : memf(a);
    sbq.push_back(e);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  // Timeline and scoreboard monitor
  bit bact = 0; int bph = 0; int bk = 0;
  logic [15:0] baddr = '0; logic [7:0] bwd = '0;
  logic [7:0] last_rd = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit e_ale, e_ps, e_rd, e_wr, e_adr, e_dat, e_done, e_rdy;
      int L;
      L      = blen(bk);
      e_ale  = bact && bph < 2;
      e_ps   = !(bact && bk == 0 && bph >= 3 && bph <= 5);
      e_rd   = !(bact && bk == 1 && bph >= 5 && bph <= 10);
      e_wr   = !(bact && bk == 2 && bph >= 5 && bph <= 10);
      e_adr  = bact && (bph == 1 || bph == 2);
      e_dat  = bact && bk == 2 && bph >= 4 && bph <= 11;
      e_done = bact && bph == L - 1;
      e_rdy  = !bact || bph == L - 1;
      chk(ale == e_ale, "R1", "ale", ale, e_ale);
      chk(psen_n == e_ps, "R3", "psen_n", psen_n, e_ps);
      chk(rd_n == e_rd && wr_n == e_wr, "R4", "rd_n/wr_n", {rd_n, wr_n}, {e_rd, e_wr});
      chk(ad_oe == (e_adr || e_dat), "R5", "ad_oe", ad_oe, e_adr || e_dat);
      if (e_adr) chk(ad_out == baddr[7:0], "R2", "ad_out addr", ad_out, baddr[7:0]);
      if (e_dat) chk(ad_out == bwd, "R6", "ad_out wdata", ad_out, bwd);
      if (bact) chk(a_hi == baddr[15:8], "R9", "a_hi", a_hi, baddr[15:8]);
      chk(done == e_done, "R8", "done", done, e_done);
      chk(req_ready == e_rdy, "R7", "req_ready", req_ready, e_rdy);
      chk($onehot0({~psen_n, ~rd_n, ~wr_n}), "R10", "strobes", {psen_n, rd_n, wr_n}, 7);
      if (done) begin
        if (sbq.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.kind == 2) chk(rdata == last_rd, "R8", "rdata after write", rdata, last_rd);
          else begin
            chk(rdata == e.val, "R8", "rdata", rdata, e.val);
            last_rd = e.val;
          end
        end
      end
      // advance the bench's own cycle model (R11: only taken when ready)
      if (req_valid && req_ready) begin
        bact = 1; bph = 0; bk = kmap(req_kind); baddr = req_addr; bwd = req_wdata;
      end else if (bact) begin
        if (bph == L - 1) bact = 0; else bph = bph + 1;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R12: reset state
    chk(ale == 0 && psen_n && rd_n && wr_n && !ad_oe && !done && req_ready,
        "R12", "reset idle", {ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}, 7'b0111001);
    @(posedge clk); #2; rst = 1'b0;
    repeat (2) @(posedge clk); #2;
    issue(2'b00, 16'h1234, 8'h00);          // fetch
    repeat (3) @(posedge clk); #2;
    issue(2'b01, 16'hA55A, 8'h00);          // read
    repeat (2) @(posedge clk); #2;
    issue(2'b10, 16'h0F0F, 8'hC3);          // write, rdata must stay
    issue(2'b11, 16'h8001, 8'h3C);          // write via 2'b11, back to back
    issue(2'b01, 16'hFF00, 8'h00);          // read straight after write
    issue(2'b00, 16'h00FF, 8'h00);          // fetch straight after read (R5 float)
    issue(2'b00, 16'h7E81, 8'h00);          // fetch after fetch
    // R11: stray request while busy, withdrawn before ready
    req_valid = 1'b1; req_kind = 2'b01; req_addr = 16'h4242;
    do @(negedge clk); while (!req_ready);
    sbq.push_back('{kind: 1, val: memf(16'h4242)});
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'hFFFF; req_wdata = 8'h99;
    repeat (5) @(posedge clk); #2;
    req_valid = 1'b0;
    for (int i = 0; i < 16; i++) issue(2'(i % 3), 16'(i * 16'h1357 + 16'h0101), 8'(i * 7));
    while (bact || sbq.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);
    finish_run();
  end

endmodule